// File: doc/BRIEF.md
# Handshake-Paced Byte Transfer Engine

This block is the device-side half of a byte-wide packet link between a host processor and a local command processor. Three active-low lines pace the traffic. The host owns a "transfer in progress" line (`prog_n`) and an "acknowledge" line (`ack_n`). The engine owns a "request" line (`req_n`), which tells the host that reply data is waiting and also marks the last byte of a reply. Each byte moves on a change of level of the host-owned lines, not on a shift clock.

A direction input picks the flow. When the host sends, each handshake change captures the host's data byte into a small outbound buffer. When the host releases `prog_n`, the engine reports the finished packet and its length to the command processor, which reads the bytes through a read port. When the engine replies, the command processor first writes the reply into the inbound buffer and loads its length. Each handshake change then presents the next reply byte on `tx_byte`. Every byte event, end of transfer, idle sync toggle and reply load produces a one-cycle `shift_evt` pulse, which the surrounding logic uses as its shift interrupt.

Top module: `hsx_engine`

## Requirements
- R1: During and straight after reset, `req_n` is 1, `tx_byte` is 0, `shift_evt` is 0 and `pkt_done` is 0.
- R2: With `prog_n`=0 and `dir_from_host`=1 (host sends), any change of `prog_n` or `ack_n` relative to the previous cycle stores `host_byte` into the next outbound slot, starting at slot 0. `shift_evt` pulses on the following cycle. Slot contents appear on `ob_rdata` for the slot addressed by `ob_raddr`.
- R3: Once OB_DEPTH bytes are held, further handshake changes store nothing, overwrite no slot and give no `shift_evt`.
- R4: When `prog_n` goes from 0 to 1, `shift_evt` always pulses. If at least one byte was collected, `pkt_done` pulses for one cycle with `pkt_len` equal to the byte count, and the next packet starts again at slot 0.
- R5: With `prog_n`=0, `dir_from_host`=0 (engine replies) and unread reply bytes, any change of `prog_n` or `ack_n` puts the next reply byte on `tx_byte` and pulses `shift_evt`.
- R6: When the byte presented under R5 is the last one of the reply, `req_n` goes to 1 on the same update.
- R7: In reply direction with no unread bytes, handshake changes leave `tx_byte` unchanged and give no `shift_evt`.
- R8: With `prog_n`=1 in both the current and the previous cycle, each toggle of `ack_n` copies the new `ack_n` level onto `req_n` and pulses `shift_evt`.
- R9: With `prog_n`=1, no `ack_n` toggle and unread reply bytes, `req_n` is driven to 0.
- R10: A `rp_load` pulse sets the reply length to `rp_len`, restarts the read position at byte 0 and pulses `shift_evt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_n | input | 1 | Transfer in progress from host, active low |
| ack_n | input | 1 | Acknowledge from host, active low |
| dir_from_host | input | 1 | 1: host sends bytes, 0: engine sends reply |
| host_byte | input | DW | Data byte shifted in by the host |
| req_n | output | 1 | Request to host, active low |
| tx_byte | output | DW | Reply byte presented to the host |
| shift_evt | output | 1 | One-cycle shift interrupt event |
| ib_we | input | 1 | Inbound (reply) buffer write enable |
| ib_waddr | input | $clog2(IB_DEPTH) | Inbound buffer write address |
| ib_wdata | input | DW | Inbound buffer write data |
| rp_load | input | 1 | Load a new reply of `rp_len` bytes |
| rp_len | input | $clog2(IB_DEPTH+1) | Reply length in bytes |
| ob_raddr | input | $clog2(OB_DEPTH) | Outbound buffer read address |
| ob_rdata | output | DW | Outbound buffer read data |
| pkt_done | output | 1 | One-cycle pulse: host packet finished |
| pkt_len | output | $clog2(OB_DEPTH+1) | Byte count of the finished packet |

## Verification
The bench builds the engine with OB_DEPTH=4 and IB_DEPTH=8 instead of the defaults of 16 and 128. The shallow outbound buffer lets a short run fill it completely, try two extra bytes and confirm that slot 0 survives. The small reply buffer keeps the last-byte release of `req_n` and the drained reply state a few handshakes away. The data width stays at 8, so byte values and buffer indexing are exercised exactly as in the default build.

// File: rtl/hsx_pkg.sv
package hsx_pkg;
    typedef enum logic {
        DIR_TO_HOST   = 1'b0,
        DIR_FROM_HOST = 1'b1
    } hsx_dir_e;

    typedef struct packed {
        logic prog_n;
        logic ack_n;
    } hsx_lines_t;
endpackage

// File: rtl/hsx_mem.sv
module hsx_mem #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/hsx_edge.sv
module hsx_edge
    import hsx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic prog_n,
    input  logic ack_n,
    output logic prev_prog_n,
    output logic pair_chg,
    output logic ack_chg
);
    hsx_lines_t lines_d, lines_q;

    always_comb begin
        lines_d.prog_n = prog_n;
        lines_d.ack_n  = ack_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lines_q <= '{prog_n: 1'b1, ack_n: 1'b1};
        else        lines_q <= lines_d;
    end

    assign prev_prog_n = lines_q.prog_n;
    assign ack_chg     = ack_n != lines_q.ack_n;
    assign pair_chg    = ack_chg || (prog_n != lines_q.prog_n);
endmodule

// File: rtl/hsx_engine.sv
module hsx_engine
    import hsx_pkg::*;
#(
    parameter int DW       = 8,
    parameter int OB_DEPTH = 16,
    parameter int IB_DEPTH = 128,
    localparam int OB_AW   = $clog2(OB_DEPTH),
    localparam int IB_AW   = $clog2(IB_DEPTH),
    localparam int OB_CW   = $clog2(OB_DEPTH + 1),
    localparam int IB_CW   = $clog2(IB_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prog_n,
    input  logic             ack_n,
    input  logic             dir_from_host,
    input  logic [DW-1:0]    host_byte,
    output logic             req_n,
    output logic [DW-1:0]    tx_byte,
    output logic             shift_evt,
    input  logic             ib_we,
    input  logic [IB_AW-1:0] ib_waddr,
    input  logic [DW-1:0]    ib_wdata,
    input  logic             rp_load,
    input  logic [IB_CW-1:0] rp_len,
    input  logic [OB_AW-1:0] ob_raddr,
    output logic [DW-1:0]    ob_rdata,
    output logic             pkt_done,
    output logic [OB_CW-1:0] pkt_len
);
    typedef struct packed {
        logic             req_n;
        logic [DW-1:0]    tx;
        logic             evt;
        logic             done;
        logic [OB_CW-1:0] done_len;
        logic [OB_CW-1:0] ob_cnt;
        logic [IB_CW-1:0] rd_idx;
        logic [IB_CW-1:0] rp_len;
    } eng_st_t;

    eng_st_t  st_d, st_q;
    hsx_dir_e dir;
    logic     prev_prog_n, pair_chg, ack_chg;
    logic     pending, ob_we;
    logic [DW-1:0] ib_rdata;

    assign dir = hsx_dir_e'(dir_from_host);

    hsx_edge u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .prog_n     (prog_n),
        .ack_n      (ack_n),
        .prev_prog_n(prev_prog_n),
        .pair_chg   (pair_chg),
        .ack_chg    (ack_chg)
    );

    // Outbound buffer: written by host bytes, read by the command processor.
    hsx_mem #(.W(DW), .DEPTH(OB_DEPTH)) u_ob_mem (
        .clk  (clk),
        .we   (ob_we),
        .waddr(st_q.ob_cnt[OB_AW-1:0]),
        .wdata(host_byte),
        .raddr(ob_raddr),
        .rdata(ob_rdata)
    );

    // Inbound buffer: filled by the command processor, read at the reply index.
    hsx_mem #(.W(DW), .DEPTH(IB_DEPTH)) u_ib_mem (
        .clk  (clk),
        .we   (ib_we),
        .waddr(ib_waddr),
        .wdata(ib_wdata),
        .raddr(st_q.rd_idx[IB_AW-1:0]),
        .rdata(ib_rdata)
    );

    always_comb begin
        st_d      = st_q;
        st_d.evt  = 1'b0;
        st_d.done = 1'b0;
        ob_we     = 1'b0;
        pending   = st_q.rd_idx < st_q.rp_len;

        if (!prog_n) begin
            if (dir == DIR_FROM_HOST) begin
                if (pair_chg && st_q.ob_cnt < OB_CW'(OB_DEPTH)) begin
                    ob_we       = 1'b1;
                    st_d.ob_cnt = st_q.ob_cnt + OB_CW'(1);
                    st_d.evt    = 1'b1;
                end
            end else if (pending && pair_chg) begin
                st_d.tx     = ib_rdata;
                st_d.rd_idx = st_q.rd_idx + IB_CW'(1);
                st_d.evt    = 1'b1;
                if (st_q.rd_idx + IB_CW'(1) >= st_q.rp_len) st_d.req_n = 1'b1;
            end
        end else if (prev_prog_n && ack_chg) begin
            st_d.req_n = ack_n;
            st_d.evt   = 1'b1;
        end else begin
            if (!prev_prog_n) begin
                st_d.evt = 1'b1;
                if (st_q.ob_cnt != '0) begin
                    st_d.done     = 1'b1;
                    st_d.done_len = st_q.ob_cnt;
                    st_d.ob_cnt   = '0;
                end
            end
            if (pending) st_d.req_n = 1'b0;
        end

        if (rp_load) begin
            st_d.rd_idx = '0;
            st_d.rp_len = rp_len;
            st_d.evt    = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.req_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_n     = st_q.req_n;
    assign tx_byte   = st_q.tx;
    assign shift_evt = st_q.evt;
    assign pkt_done  = st_q.done;
    assign pkt_len   = st_q.done_len;

    // R3
    ob_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ob_cnt <= OB_CW'(OB_DEPTH));

    // R4
    done_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> st_q.done_len != '0);

    // R4
    done_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> ($past(prog_n) && !$past(prev_prog_n)));

    // R6
    last_byte_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!prog_n && dir == DIR_TO_HOST && pair_chg && pending
         && (st_q.rd_idx + IB_CW'(1) == st_q.rp_len)) |=> req_n);

    // R7
    drained_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!prog_n && dir == DIR_TO_HOST && !pending && !rp_load)
        |=> (!shift_evt && $stable(tx_byte)));

    // R10
    load_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rp_load |=> (shift_evt && st_q.rd_idx == '0));
endmodule

// File: tb/hsx_engine_bench.sv
module hsx_engine_bench;
    localparam int DW = 8, OBD = 4, IBD = 8;
    localparam int OB_AW = $clog2(OBD), IB_AW = $clog2(IBD);
    localparam int OB_CW = $clog2(OBD + 1), IB_CW = $clog2(IBD + 1);

    logic clk = 1'b0, rst_n = 1'b0;
    logic prog_n = 1'b1, ack_n = 1'b1, dir_from_host = 1'b1;
    logic [DW-1:0] host_byte = '0, ib_wdata = '0;
    logic ib_we = 1'b0, rp_load = 1'b0;
    logic [IB_AW-1:0] ib_waddr = '0;
    logic [IB_CW-1:0] rp_len = '0;
    logic [OB_AW-1:0] ob_raddr = '0;
    logic req_n, shift_evt, pkt_done;
    logic [DW-1:0] tx_byte, ob_rdata;
    logic [OB_CW-1:0] pkt_len;
    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    hsx_engine #(.DW(DW), .OB_DEPTH(OBD), .IB_DEPTH(IBD)) u_hsx_engine (
        .clk(clk), .rst_n(rst_n), .prog_n(prog_n), .ack_n(ack_n),
        .dir_from_host(dir_from_host), .host_byte(host_byte), .req_n(req_n),
        .tx_byte(tx_byte), .shift_evt(shift_evt), .ib_we(ib_we),
        .ib_waddr(ib_waddr), .ib_wdata(ib_wdata), .rp_load(rp_load),
        .rp_len(rp_len), .ob_raddr(ob_raddr), .ob_rdata(ob_rdata),
        .pkt_done(pkt_done), .pkt_len(pkt_len)
    );

    // Vector: [17] prog_n [16] ack_n [15] dir [14:7] byte [6] evt [5] done [4:0] len
    localparam logic [17:0] VEC [6] = '{
        {1'b0, 1'b1, 1'b1, 8'hA1, 1'b1, 1'b0, 5'd0},
        {1'b0, 1'b0, 1'b1, 8'hB2, 1'b1, 1'b0, 5'd0},
        {1'b0, 1'b0, 1'b1, 8'hC3, 1'b0, 1'b0, 5'd0},
        {1'b0, 1'b1, 1'b1, 8'hC3, 1'b1, 1'b0, 5'd0},
        {1'b1, 1'b1, 1'b1, 8'h00, 1'b1, 1'b1, 5'd3},
        {1'b1, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0, 5'd0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic p, input logic a);
        @(negedge clk);
        prog_n = p;
        ack_n  = a;
        @(posedge clk);
        #1;
    endtask

    task automatic ib_write(input logic [IB_AW-1:0] ad, input logic [DW-1:0] dt);
        @(negedge clk);
        ib_we = 1'b1; ib_waddr = ad; ib_wdata = dt;
        @(posedge clk);
        #1;
        ib_we = 1'b0;
    endtask

    task automatic load_reply(input logic [IB_CW-1:0] n);
        @(negedge clk);
        rp_load = 1'b1; rp_len = n;
        @(posedge clk);
        #1;
        rp_load = 1'b0;
    endtask

    task automatic ob_read(input string tag, input logic [OB_AW-1:0] ad, input logic [DW-1:0] exp);
        ob_raddr = ad;
        #1;
        chk(tag, ob_rdata, exp);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 req_n in reset", req_n, 1);
        chk("R1 tx_byte in reset", tx_byte, 0);
        chk("R1 shift_evt in reset", shift_evt, 0);
        chk("R1 pkt_done in reset", pkt_done, 0);
        @(negedge clk);
        rst_n = 1'b1;
        step(1, 1);
        chk("R1 idle after reset evt", shift_evt, 0);
        chk("R1 idle after reset req_n", req_n, 1);

        // Host-send packet walked from the table
        for (int i = 0; i < 6; i++) begin
            dir_from_host = VEC[i][15];
            host_byte     = VEC[i][14:7];
            step(VEC[i][17], VEC[i][16]);
            chk($sformatf("R2 evt vec%0d", i), shift_evt, VEC[i][6]);
            chk($sformatf("R4 done vec%0d", i), pkt_done, VEC[i][5]);
            if (VEC[i][5]) chk($sformatf("R4 len vec%0d", i), pkt_len, VEC[i][4:0]);
        end
        ob_read("R2 slot0", 0, 8'hA1);
        ob_read("R2 slot1", 1, 8'hB2);
        ob_read("R2 slot2", 2, 8'hC3);

        // R3: fill the outbound buffer and push past it
        dir_from_host = 1'b1;
        for (int i = 0; i < 6; i++) begin
            host_byte = 8'h40 + 8'(i);
            step(1'b0, (i % 2) == 0);
            chk($sformatf("R3 evt byte%0d", i), shift_evt, i < OBD);
        end
        step(1, 0);
        chk("R4 done full", pkt_done, 1);
        chk("R4 len full", pkt_len, OBD);
        ob_read("R3 slot0 kept", 0, 8'h40);
        ob_read("R3 last slot", 3, 8'h43);

        // R4: next packet restarts at slot 0
        host_byte = 8'h77;
        step(0, 0);
        chk("R2 evt restart", shift_evt, 1);
        step(1, 0);
        chk("R4 done restart", pkt_done, 1);
        chk("R4 len restart", pkt_len, 1);
        ob_read("R4 restart slot0", 0, 8'h77);

        // R8: idle sync toggles
        step(1, 1);
        chk("R8 req_n follows ack 1", req_n, 1);
        chk("R8 evt toggle 1", shift_evt, 1);
        step(1, 0);
        chk("R8 req_n follows ack 0", req_n, 0);
        chk("R8 evt toggle 0", shift_evt, 1);
        step(1, 1);
        chk("R8 req_n follows ack 1b", req_n, 1);

        // Reply path
        ib_write(0, 8'hD0);
        ib_write(1, 8'hD1);
        ib_write(2, 8'hD2);
        load_reply(3);
        chk("R10 evt on load", shift_evt, 1);
        step(1, 1);
        chk("R9 req_n pending", req_n, 0);
        chk("R9 no evt idle", shift_evt, 0);
        dir_from_host = 1'b0;
        step(0, 1);
        chk("R5 tx byte0", tx_byte, 8'hD0);
        chk("R5 evt byte0", shift_evt, 1);
        chk("R6 req_n mid", req_n, 0);
        step(0, 0);
        chk("R5 tx byte1", tx_byte, 8'hD1);
        step(0, 1);
        chk("R5 tx byte2", tx_byte, 8'hD2);
        chk("R6 req_n last", req_n, 1);
        step(0, 0);
        chk("R7 no evt drained", shift_evt, 0);
        chk("R7 tx held", tx_byte, 8'hD2);
        step(1, 0);
        chk("R4 evt on release", shift_evt, 1);
        chk("R4 no done empty", pkt_done, 0);
        chk("R9 req_n idle drained", req_n, 1);

        // R10: reload restarts at byte 0, single-byte reply releases req at once
        load_reply(1);
        chk("R10 evt reload", shift_evt, 1);
        step(1, 0);
        chk("R9 req_n pending reload", req_n, 0);
        step(0, 0);
        chk("R10 tx restart byte0", tx_byte, 8'hD0);
        chk("R6 req_n single", req_n, 1);
        step(1, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule